// File: doc/BRIEF.md
# Command-Decoded Serial Configuration Register Slave

This block receives configuration traffic from a host over a four-wire serial link with an active-low select, and keeps a small register file whose fields drive a frequency-agile radio transmitter: modulation choice, antenna tuning capacitance, clock divider, two 16-bit synthesizer words, a transmit-data bit, a transmit-enable bit and an output-pin selector. The serial pins are taken into the system clock domain through synchronizers. Rising and falling serial-clock edges are found there, and all protocol work runs on the system clock.

Each select frame opens with a command byte. One command writes a burst of bytes to successive addresses. One reads in a pipelined manner, where every byte the host sends names the register to be returned in the following byte. One arms a streaming read whose data comes out in the next frame. One restores every register to its power-up value. The frequency-load register does not hold its value: writing a one to it makes a single-cycle strobe that tells the synthesizer to take the new frequency words. One control bit lets the link go deaf while the transmitter is in standby.

Top module: `spi_rf_cfg_slave`

## Requirements
- R1: Bits are taken most significant first on rising serial-clock edges while `spi_csn` is low. A frame that ends with fewer than 8 bits in the current byte discards that byte without effect.
- R2: Command 0x01 takes the next byte as a start address. Each byte after that is written to the current address, and the address then advances by one, wrapping from 0xFF to 0x00.
- R3: After command 0x02, every received byte is an address, and that register's value is shifted out during the following byte. The bytes returned while the command byte and the first address are received carry no data.
- R4: Command 0x03 followed by an address arms a streaming read. In the next frame the slave returns that register in the first byte and successive addresses in later bytes, whatever the host sends. A frame that starts disarms it.
- R5: Command 0x04 returns all registers to 0x00, which selects ASK modulation.
- R6: Map: 0x00 control (bit0 FSK mode, bit1 envelope shaping, bit2 wide loop bandwidth, bit3 clock-out enable, bit4 clock-out select, bit5 link-off-in-standby); 0x01 tuning cap in bits 4:0 and divider in bits 7:5; 0x02/0x03 high word MSB/LSB; 0x04/0x05 low word MSB/LSB; 0x07 bit0 tx data; 0x08 bit0 tx enable; 0x09 bits 2:0 output select. Unused bits read back 0.
- R7: Writes to addresses above 0x09, including the read-only status address 0x0C, change nothing. A read of 0x0C returns `status_in`. Reads of other unmapped addresses return 0x00.
- R8: Writing a byte with bit0 set to address 0x06 produces exactly one one-cycle `freq_load` pulse. Address 0x06 always reads 0x00.
- R9: When control bit5 is 1 and `run_en` is low at the start of a frame, that whole frame is ignored: nothing is written or reset, nothing is armed, and `spi_miso` stays 0.
- R10: While `spi_csn` is low, `spi_miso` changes only after a falling serial-clock edge or at the start of a frame.
- R11: Any command byte other than 0x01 to 0x04 makes the slave ignore the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-assert active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| run_en | input | 1 | High when the transmitter is out of standby |
| status_in | input | 8 | Value returned for the read-only status address |
| fsk_mode | output | 1 | 1 = FSK, 0 = ASK |
| env_shape | output | 1 | Envelope shaping on |
| pll_wide | output | 1 | Wide loop bandwidth |
| clkout_en | output | 1 | Clock output enable |
| clkout_sel | output | 1 | Clock output select |
| cap_sel | output | 5 | Antenna tuning capacitor code |
| clk_div | output | 3 | Clock output divider code |
| freq_hi | output | 16 | Upper synthesizer word |
| freq_lo | output | 16 | Lower synthesizer word |
| freq_load | output | 1 | One-cycle frequency load strobe |
| tx_data | output | 1 | Transmit data bit |
| tx_en | output | 1 | Transmit enable bit |
| gpo_sel | output | 3 | Output pin function select |

## Verification
The assertions assume the serial clock is idle low at every select edge, and that each serial-clock level and each select level lasts well over the synchronizer depth plus two system clocks. Under that assumption a byte completion never coincides with a frame start, and the pending output byte is always in place before the falling edge that uses it. The bench holds every serial-clock half period at ten system clocks and changes data only while the serial clock is low, so it never breaks these assumptions.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int NREG   = 10;

  localparam logic [7:0] CMD_WRITE = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h02;
  localparam logic [7:0] CMD_RDALL = 8'h03;
  localparam logic [7:0] CMD_RESET = 8'h04;

  localparam logic [7:0] ADR_CTRL = 8'h00;
  localparam logic [7:0] ADR_TUNE = 8'h01;
  localparam logic [7:0] ADR_LOAD = 8'h06;
  localparam logic [7:0] ADR_DATA = 8'h07;
  localparam logic [7:0] ADR_TXEN = 8'h08;
  localparam logic [7:0] ADR_GPO  = 8'h09;
  localparam logic [7:0] ADR_STAT = 8'h0C;

  typedef enum logic [2:0] {
    ST_CMD, ST_WADDR, ST_WDATA, ST_RADDR, ST_RAADDR, ST_STREAM, ST_DROP
  } fsm_e;

  // Writable bits for each stored address; zero means nothing is kept.
  function automatic logic [BYTE_W-1:0] wr_mask(input logic [7:0] a);
    case (a)
      ADR_CTRL:                    wr_mask = 8'h3F;
      ADR_TUNE:                    wr_mask = 8'hFF;
      8'h02, 8'h03, 8'h04, 8'h05:  wr_mask = 8'hFF;
      ADR_LOAD:                    wr_mask = 8'h00;
      ADR_DATA, ADR_TXEN:          wr_mask = 8'h01;
      ADR_GPO:                     wr_mask = 8'h07;
      default:                     wr_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic cs_start,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_q, csn_q, mosi_q;
  logic sck_d, act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      csn_q  <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
      act_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck_i};
      csn_q  <= {csn_q[STAGES-2:0], csn_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      sck_d  <= sck_q[TOP];
      act_d  <= ~csn_q[TOP];
    end
  end

  assign sck_rise  = sck_q[TOP] & ~sck_d;
  assign sck_fall  = ~sck_q[TOP] & sck_d;
  assign cs_active = ~csn_q[TOP];
  assign cs_start  = ~csn_q[TOP] & ~act_d;
  assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              cs_start,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      pend     <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_active) begin
        bitcnt <= '0;
        tx_sh  <= '0;
        pend   <= '0;
      end else if (cs_start) begin
        bitcnt <= '0;
        pend   <= '0;
        tx_sh  <= tx_load ? tx_byte : '0;
      end else begin
        if (sck_rise) begin
          rx_sh  <= {rx_sh[BYTE_W-2:0], mosi_s};
          bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
          if (bitcnt == LAST) rx_valid <= 1'b1;
        end
        if (tx_load) pend <= tx_byte;
        if (sck_fall) begin
          if (bitcnt == '0) begin
            tx_sh <= pend;
            pend  <= '0;
          end else begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign rx_byte = rx_sh;
  assign miso    = cs_active & tx_sh[BYTE_W-1];

  // R10: output bit only moves on a falling serial edge or a frame start
  assert_miso_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !sck_fall && !cs_start) |=> (!cs_active || $stable(miso)));
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [7:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [BYTE_W-1:0] status_in,
  output logic              fsk_mode,
  output logic              env_shape,
  output logic              pll_wide,
  output logic              clkout_en,
  output logic              clkout_sel,
  output logic              spi_off,
  output logic [4:0]        cap_sel,
  output logic [2:0]        clk_div,
  output logic [15:0]       freq_hi,
  output logic [15:0]       freq_lo,
  output logic              freq_load,
  output logic              tx_data,
  output logic              tx_en,
  output logic [2:0]        gpo_sel
);
  localparam int IDX_W = $clog2(NREG);

  logic [BYTE_W-1:0] regs [NREG];
  logic [NREG*BYTE_W-1:0] flat;
  logic wr_mapped, rd_mapped;

  assign wr_mapped = (wr_addr < 8'(NREG));
  assign rd_mapped = (rd_addr < 8'(NREG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      freq_load <= 1'b0;
    end else if (soft_rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      freq_load <= 1'b0;
    end else begin
      freq_load <= wr_en && (wr_addr == ADR_LOAD) && wr_data[0];
      if (wr_en && wr_mapped)
        regs[wr_addr[IDX_W-1:0]] <= wr_data & wr_mask(wr_addr);
    end
  end

  always_comb begin
    if (rd_mapped)                rd_data = regs[rd_addr[IDX_W-1:0]];
    else if (rd_addr == ADR_STAT) rd_data = status_in;
    else                          rd_data = '0;
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign flat[g*BYTE_W +: BYTE_W] = regs[g];
    end
  endgenerate

  assign fsk_mode   = regs[0][0];
  assign env_shape  = regs[0][1];
  assign pll_wide   = regs[0][2];
  assign clkout_en  = regs[0][3];
  assign clkout_sel = regs[0][4];
  assign spi_off    = regs[0][5];
  assign cap_sel    = regs[1][4:0];
  assign clk_div    = regs[1][7:5];
  assign freq_hi    = {regs[2], regs[3]};
  assign freq_lo    = {regs[4], regs[5]};
  assign tx_data    = regs[7][0];
  assign tx_en      = regs[8][0];
  assign gpo_sel    = regs[9][2:0];

  // R5: soft reset leaves every field at zero
  assert_soft_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flat == '0 && !freq_load));

  // R8: load strobe lasts a single cycle
  assert_load_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |=> !freq_load);

  // R7: writes outside the stored range leave the file untouched
  assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst && !wr_mapped) |=> $stable(flat));
endmodule

// File: rtl/spi_rf_cfg_slave.sv
module spi_rf_cfg_slave
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  input  logic        run_en,
  input  logic [7:0]  status_in,
  output logic        fsk_mode,
  output logic        env_shape,
  output logic        pll_wide,
  output logic        clkout_en,
  output logic        clkout_sel,
  output logic [4:0]  cap_sel,
  output logic [2:0]  clk_div,
  output logic [15:0] freq_hi,
  output logic [15:0] freq_lo,
  output logic        freq_load,
  output logic        tx_data,
  output logic        tx_en,
  output logic [2:0]  gpo_sel
);
  logic sck_rise, sck_fall, cs_active, cs_start, mosi_s;
  logic rx_valid, tx_load, wr_en, soft_rst, spi_off, blocked;
  logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data;
  logic [7:0] rd_addr, ptr, ra_ptr;
  logic ra_armed, frame_blk;
  fsm_e state;

  spi_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .csn_i(spi_csn), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active),
    .cs_start(cs_start), .mosi_s(mosi_s)
  );

  spi_rf_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cs_start(cs_start),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .tx_load(tx_load), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_rf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_addr(ptr), .wr_data(rx_byte), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_in(status_in),
    .fsk_mode(fsk_mode), .env_shape(env_shape), .pll_wide(pll_wide),
    .clkout_en(clkout_en), .clkout_sel(clkout_sel), .spi_off(spi_off),
    .cap_sel(cap_sel), .clk_div(clk_div), .freq_hi(freq_hi), .freq_lo(freq_lo),
    .freq_load(freq_load), .tx_data(tx_data), .tx_en(tx_en), .gpo_sel(gpo_sel)
  );

  assign blocked = spi_off & ~run_en;

  // Per-byte decisions: which register feeds the next output byte, and what to write.
  always_comb begin
    tx_load  = 1'b0;
    tx_byte  = '0;
    rd_addr  = rx_byte;
    wr_en    = 1'b0;
    soft_rst = 1'b0;
    if (cs_start) begin
      rd_addr = ra_ptr;
      tx_load = 1'b1;
      if (!blocked && ra_armed) tx_byte = rd_data;
    end else if (rx_valid) begin
      case (state)
        ST_CMD:    soft_rst = (rx_byte == CMD_RESET);
        ST_WDATA:  wr_en = 1'b1;
        ST_RADDR: begin
          tx_load = 1'b1;
          tx_byte = rd_data;
        end
        ST_STREAM: begin
          rd_addr = ptr;
          tx_load = 1'b1;
          tx_byte = rd_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_DROP;
      ptr       <= '0;
      ra_ptr    <= '0;
      ra_armed  <= 1'b0;
      frame_blk <= 1'b0;
    end else if (cs_start) begin
      ra_armed  <= 1'b0;
      frame_blk <= blocked;
      if (blocked)       state <= ST_DROP;
      else if (ra_armed) begin
        state <= ST_STREAM;
        ptr   <= ra_ptr + 8'd1;
      end else           state <= ST_CMD;
    end else if (rx_valid) begin
      case (state)
        ST_CMD: begin
          case (rx_byte)
            CMD_WRITE: state <= ST_WADDR;
            CMD_READ:  state <= ST_RADDR;
            CMD_RDALL: state <= ST_RAADDR;
            default:   state <= ST_DROP;
          endcase
        end
        ST_WADDR: begin
          ptr   <= rx_byte;
          state <= ST_WDATA;
        end
        ST_WDATA:  ptr <= ptr + 8'd1;
        ST_RAADDR: begin
          ra_ptr   <= rx_byte;
          ra_armed <= 1'b1;
          state    <= ST_DROP;
        end
        ST_STREAM: ptr <= ptr + 8'd1;
        default: ;
      endcase
    end
  end

  // R1: a completed byte never lands on the cycle a frame opens
  assert_frame_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !cs_start);

  // R9: a frame opened in standby with the link-off bit set cannot change state
  assert_blocked_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_blk && cs_active && !cs_start) |-> (!wr_en && !soft_rst && !spi_miso));
endmodule

// File: tb/tb_spi_rf_cfg_slave.sv
module tb_spi_rf_cfg_slave;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic run_en = 1'b1;
  logic [7:0] status_in = 8'hA5;
  logic spi_miso, fsk_mode, env_shape, pll_wide, clkout_en, clkout_sel;
  logic [4:0] cap_sel;
  logic [2:0] clk_div, gpo_sel;
  logic [15:0] freq_hi, freq_lo;
  logic freq_load, tx_data, tx_en;

  int tests = 0, fails = 0, loadcnt = 0, miso_bad = 0;
  bit done = 1'b0;
  logic [7:0] mdl [16];
  logic miso_prev = 1'b0;

  always #4 clk = ~clk;

  spi_rf_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .run_en(run_en), .status_in(status_in),
    .fsk_mode(fsk_mode), .env_shape(env_shape), .pll_wide(pll_wide),
    .clkout_en(clkout_en), .clkout_sel(clkout_sel), .cap_sel(cap_sel),
    .clk_div(clk_div), .freq_hi(freq_hi), .freq_lo(freq_lo), .freq_load(freq_load),
    .tx_data(tx_data), .tx_en(tx_en), .gpo_sel(gpo_sel)
  );

  always @(posedge clk) if (freq_load) loadcnt++;
  // R10 monitor: output may not move while the serial clock is high inside a frame
  always @(negedge clk) begin
    if (!spi_csn && spi_sck && spi_miso !== miso_prev) miso_bad++;
    miso_prev = spi_miso;
  end

  function automatic logic [7:0] bmask(input logic [7:0] a);
    case (a)
      8'h00: return 8'h3F;
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05: return 8'hFF;
      8'h07, 8'h08: return 8'h01;
      8'h09: return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expv(input logic [7:0] a);
    if (a == 8'h0C) return status_in;
    if (a < 8'd10) return mdl[a[3:0]];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin();
    spi_csn = 1'b0;
    tick(HALF);
  endtask

  task automatic frame_end();
    tick(HALF);
    spi_csn = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic xbits(input logic [7:0] tb, input int n, output logic [7:0] rb);
    rb = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tb[i];
      tick(HALF);
      rb[i] = spi_miso;
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tb, output logic [7:0] rb);
    xbits(tb, 8, rb);
  endtask

  task automatic mdl_put(input logic [7:0] a, input logic [7:0] v);
    if (a < 8'd10) mdl[a[3:0]] = v & bmask(a);
  endtask

  task automatic wr_burst(input logic [7:0] start, input int n, input int seed, input bit upd);
    logic [7:0] r, v, a;
    frame_begin();
    xbyte(8'h01, r);
    xbyte(start, r);
    for (int k = 0; k < n; k++) begin
      v = 8'((seed * 89 + k * 37 + 5) & 8'hFF);
      a = start + 8'(k);
      xbyte(v, r);
      if (upd) mdl_put(a, v);
    end
    frame_end();
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] v, input bit upd);
    logic [7:0] r;
    frame_begin();
    xbyte(8'h01, r);
    xbyte(a, r);
    xbyte(v, r);
    frame_end();
    if (upd) mdl_put(a, v);
  endtask

  // R3 sweep: all 16 low addresses in descending order, then the closing 0x00
  task automatic rd_sweep(input string tag);
    logic [7:0] r, prev;
    prev = 8'h00;
    frame_begin();
    xbyte(8'h02, r);
    for (int a = 15; a >= 0; a--) begin
      xbyte(8'(a), r);
      if (a != 15) chk(tag, {24'h0, r}, {24'h0, expv(prev)});
      prev = 8'(a);
    end
    xbyte(8'h00, r);
    chk(tag, {24'h0, r}, {24'h0, expv(prev)});
    frame_end();
  endtask

  task automatic rdall(input logic [7:0] start, input int n);
    logic [7:0] r;
    frame_begin();
    xbyte(8'h03, r);
    xbyte(start, r);
    frame_end();
    frame_begin();
    for (int k = 0; k < n; k++) begin
      xbyte(8'h5A, r);
      chk("R4 read-all stream", {24'h0, r}, {24'h0, expv(start + 8'(k))});
    end
    frame_end();
  endtask

  task automatic chk_fields(input string tag);
    chk({tag, " R6 control"}, {27'h0, clkout_sel, clkout_en, pll_wide, env_shape, fsk_mode},
        {27'h0, mdl[0][4:0]});
    chk({tag, " R6 tune"}, {24'h0, clk_div, cap_sel}, {24'h0, mdl[1]});
    chk({tag, " R6 freq"}, {freq_hi, freq_lo}, {mdl[2], mdl[3], mdl[4], mdl[5]});
    chk({tag, " R6 misc"}, {27'h0, gpo_sel, tx_en, tx_data}, {27'h0, mdl[9][2:0], mdl[8][0], mdl[7][0]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int c0;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk_fields("reset");
    chk("R6 reset miso", {31'h0, spi_miso}, 32'h0);

    // R2/R6: burst writes over the whole map with several patterns
    for (int p = 0; p < 4; p++) begin
      wr_burst(8'h00, 10, p, 1'b1);
      chk_fields("R2 burst");
      rd_sweep("R3 read pipeline");
    end

    // R2 wrap from 0xFF to 0x00; R7 burst running into unmapped and status addresses
    wr_burst(8'hFF, 3, 7, 1'b1);
    chk_fields("R2 wrap");
    wr_burst(8'h08, 7, 9, 1'b1);
    status_in = 8'h3C;
    rd_sweep("R7 unmapped/status");

    // R4 streaming read across two frames, including wrap and status
    rdall(8'h02, 11);
    rdall(8'hFE, 4);

    // R1 partial byte dropped
    frame_begin();
    xbyte(8'h01, r);
    xbyte(8'h07, r);
    xbits(8'hFF, 5, r);
    frame_end();
    rd_sweep("R1 partial byte");

    // R8 load strobe
    c0 = loadcnt;
    wr1(8'h06, 8'h01, 1'b1);
    chk("R8 one load pulse", loadcnt - c0, 1);
    wr1(8'h06, 8'hFE, 1'b1);
    chk("R8 no pulse for bit0 clear", loadcnt - c0, 1);
    rd_sweep("R8 load reads zero");

    // R9 link off in standby
    wr1(8'h00, 8'h20, 1'b1);
    run_en = 1'b0;
    tick(4);
    wr1(8'h01, 8'h00, 1'b0);
    c0 = loadcnt;
    wr1(8'h06, 8'h01, 1'b0);
    chk("R9 no load when blocked", loadcnt - c0, 0);
    frame_begin();
    xbyte(8'h02, r);
    xbyte(8'h01, r);
    xbyte(8'h00, r);
    chk("R9 blocked read returns zero", {24'h0, r}, 32'h0);
    frame_end();
    frame_begin();
    xbyte(8'h04, r);
    frame_end();
    run_en = 1'b1;
    tick(4);
    chk_fields("R9 blocked");
    rd_sweep("R9 after blocked");
    wr1(8'h00, 8'h00, 1'b1);

    // R11 unknown command
    frame_begin();
    xbyte(8'h07, r);
    xbyte(8'h01, r);
    xbyte(8'h03, r);
    xbyte(8'h55, r);
    frame_end();
    rd_sweep("R11 unknown command");

    // R5 soft reset
    frame_begin();
    xbyte(8'h04, r);
    frame_end();
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    chk_fields("R5 soft reset");
    chk("R5 ASK after reset", {31'h0, fsk_mode}, 32'h0);
    rd_sweep("R5 readback");

    chk("R10 miso stable while sck high", miso_bad, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule